// File: doc/BRIEF.md
# Class-Pruned Virtual Channel Allocator

This block hands out output virtual channels to packets that are waiting in the input virtual channels of a router. Each port carries a fixed group of virtual channels. They are organised by message class (request or reply), then by resource class (minimal or non-minimal), then by a small number of channels per resource class. An input channel of the minimal resource class may only be handed a minimal output channel. An input channel of the non-minimal resource class may be handed either kind. The message class never changes on the way through.

Because every input channel can only ever compete for the output channels of its own message class on its target port, the allocator never builds the full port-times-channel request matrix. Each message class gets its own allocation core. Inside that core, an input arbiter spans only the channels of one class on one port, and an output arbiter spans only the input channels of one message class. The set of legal assignments is still the same as with an unpruned allocator. A parameter picks the core: separable input-first, separable output-first, or wavefront.

Grants are combinational from the request, busy and class inputs, so the upstream logic sees them in the cycle they are asked for. Only the arbitration priority is registered. Upstream logic uses the claim output to mark the granted output channels busy. It clears the busy flag when the tail flit leaves.

Top module: `vca_sparse`

## Requirements
- R1: Virtual channel index g = port*VPP + msg*VPM + local, with VPM = 2*VCS_PER_RES and VPP = NUM_MSG*VPM. The local index is res*VCS_PER_RES + k, where res 0 is minimal and res 1 is non-minimal. `ivc_gnt_o[g]` is a zero- or one-hot vector over the local index of the output channel. That channel is on port `ivc_port_i[g]` and in the message class of input g. Two input channels that want different free output channels are both granted in the same cycle.
- R2: An input channel with `ivc_nonmin_i` low is only granted local indices below VCS_PER_RES (the minimal channels).
- R3: An input channel with `ivc_nonmin_i` high may be granted any local index of its own message class. It is never granted a channel of another message class.
- R4: An output channel whose `ovc_busy_i` bit is high is never granted. Once the bit is low, the channel can be granted in the same cycle.
- R5: Each output channel is granted to at most one input channel per cycle. `ovc_claim_o` is high exactly for the output channels granted in that cycle.
- R6: An input channel without `ivc_req_i` receives no grant. With no requests after reset, all grant and claim outputs are low.
- R7: Whenever some requesting input channel has a free, legal output channel, at least one grant is issued in that cycle.
- R8: Suppose two input channels both hold a request for the same single free output channel, in the default separable input-first mode. Then exactly one of them is granted each cycle, and the winners alternate from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the arbitration priority state |
| rst_ni | input | 1 | Asynchronous active-low reset of the priority state |
| ivc_req_i | input | NUM_VC | Per input channel: wants an output channel |
| ivc_port_i | input | NUM_VC x PORT_W | Per input channel: target output port |
| ivc_nonmin_i | input | NUM_VC | Per input channel: resource class, 1 = non-minimal (may also use minimal) |
| ovc_busy_i | input | NUM_VC | Per output channel: already owned by a packet |
| ivc_gnt_o | output | NUM_VC x VPM | Per input channel: one-hot local index of the granted output channel |
| ovc_claim_o | output | NUM_VC | Per output channel: granted this cycle, to be marked busy |

## Verification
Two functions can fall in the same cycle: contention between input channels for one output channel, and a busy flag that blocks the other output channels those inputs could use. The bench provokes this by holding two minimal-class requests aimed at one port while every other minimal channel there stays busy. It judges the result by one grant per cycle with alternating winners. Randomised cycles also mix requests with busy flags that change each cycle. Each of these cycles is judged against a full-matrix reference with masking, for legality, freedom from conflicts and work conservation.

// File: rtl/vca_pkg.sv
package vca_pkg;

   typedef enum logic [1:0] {
      ALLOC_SEP_IN  = 2'd0,
      ALLOC_SEP_OUT = 2'd1,
      ALLOC_WAVE    = 2'd2
   } alloc_kind_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] req_i,
   input  logic             adv_i,
   output logic [WIDTH-1:0] gnt_o
);

   localparam int unsigned PW = vca_pkg::idx_w(WIDTH);

   logic [PW-1:0]    ptr_q;
   logic [PW-1:0]    win_idx;
   logic [WIDTH-1:0] hi_mask;
   logic [WIDTH-1:0] req_hi;
   logic [WIDTH-1:0] pick_src;

   always_comb begin
      for (int k = 0; k < WIDTH; k++) begin
         hi_mask[k] = (PW'(k) >= ptr_q);
      end
   end

   assign req_hi   = req_i & hi_mask;
   assign pick_src = (|req_hi) ? req_hi : req_i;

   always_comb begin
      gnt_o   = '0;
      win_idx = '0;
      for (int k = WIDTH - 1; k >= 0; k--) begin
         if (pick_src[k]) begin
            gnt_o    = '0;
            gnt_o[k] = 1'b1;
            win_idx  = PW'(k);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
      end else if (adv_i && (|req_i)) begin
         ptr_q <= (win_idx == PW'(WIDTH - 1)) ? '0 : win_idx + PW'(1);
      end
   end

endmodule

// File: rtl/vca_sep_core.sv
module vca_sep_core #(
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned VPM       = 4,
   parameter bit          OUT_FIRST = 1'b0
) (
   input  logic                                       clk_i,
   input  logic                                       rst_ni,
   input  logic [NUM_PORTS*VPM-1:0][VPM-1:0]          req_loc_i,
   input  logic [NUM_PORTS*VPM-1:0][vca_pkg::idx_w(NUM_PORTS)-1:0] port_i,
   output logic [NUM_PORTS*VPM-1:0][VPM-1:0]          gnt_loc_o
);

   localparam int unsigned NI     = NUM_PORTS * VPM;
   localparam int unsigned NO     = NI;
   localparam int unsigned PORT_W = vca_pkg::idx_w(NUM_PORTS);

   logic [NI-1:0][VPM-1:0] in_req;
   logic [NI-1:0][VPM-1:0] in_gnt;
   logic [NI-1:0]          in_adv;
   logic [NO-1:0][NI-1:0]  out_req;
   logic [NO-1:0][NI-1:0]  out_gnt;
   logic [NO-1:0]          out_adv;

   for (genvar gi = 0; gi < NI; gi++) begin : g_in_arb
      vca_rr_arb #(.WIDTH(VPM)) u_arb (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .req_i  (in_req[gi]),
         .adv_i  (in_adv[gi]),
         .gnt_o  (in_gnt[gi])
      );
   end

   for (genvar go = 0; go < NO; go++) begin : g_out_arb
      vca_rr_arb #(.WIDTH(NI)) u_arb (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .req_i  (out_req[go]),
         .adv_i  (out_adv[go]),
         .gnt_o  (out_gnt[go])
      );
   end

   if (!OUT_FIRST) begin : g_input_first
      // stage 1: each input picks one local candidate
      assign in_req = req_loc_i;

      // stage 2: each output chooses among the inputs that picked it
      always_comb begin
         out_req = '0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            for (int j = 0; j < VPM; j++) begin
               for (int i = 0; i < NI; i++) begin
                  if (port_i[i] == PORT_W'(p)) begin
                     out_req[p*VPM+j][i] = in_gnt[i][j];
                  end
               end
            end
         end
      end

      always_comb begin
         gnt_loc_o = '0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            for (int j = 0; j < VPM; j++) begin
               for (int i = 0; i < NI; i++) begin
                  if (port_i[i] == PORT_W'(p)) begin
                     gnt_loc_o[i][j] = gnt_loc_o[i][j] | out_gnt[p*VPM+j][i];
                  end
               end
            end
         end
      end

      // input pointer moves only when its pick survived stage 2
      always_comb begin
         for (int i = 0; i < NI; i++) begin
            in_adv[i] = |gnt_loc_o[i];
         end
      end

      always_comb begin
         for (int o = 0; o < NO; o++) begin
            out_adv[o] = |out_req[o];
         end
      end
   end else begin : g_output_first
      // stage 1: each output offers itself to one requesting input
      always_comb begin
         out_req = '0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            for (int j = 0; j < VPM; j++) begin
               for (int i = 0; i < NI; i++) begin
                  if (port_i[i] == PORT_W'(p)) begin
                     out_req[p*VPM+j][i] = req_loc_i[i][j];
                  end
               end
            end
         end
      end

      // stage 2: each input accepts one of its offers
      always_comb begin
         in_req = '0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            for (int j = 0; j < VPM; j++) begin
               for (int i = 0; i < NI; i++) begin
                  if (port_i[i] == PORT_W'(p)) begin
                     in_req[i][j] = in_req[i][j] | out_gnt[p*VPM+j][i];
                  end
               end
            end
         end
      end

      assign gnt_loc_o = in_gnt;

      always_comb begin
         for (int i = 0; i < NI; i++) begin
            in_adv[i] = |in_req[i];
         end
      end

      // output pointer moves only when its offer was accepted
      always_comb begin
         out_adv = '0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            for (int j = 0; j < VPM; j++) begin
               for (int i = 0; i < NI; i++) begin
                  if ((port_i[i] == PORT_W'(p)) && out_gnt[p*VPM+j][i] && in_gnt[i][j]) begin
                     out_adv[p*VPM+j] = 1'b1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/vca_wf_core.sv
module vca_wf_core #(
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned VPM       = 4
) (
   input  logic                                       clk_i,
   input  logic                                       rst_ni,
   input  logic [NUM_PORTS*VPM-1:0][VPM-1:0]          req_loc_i,
   input  logic [NUM_PORTS*VPM-1:0][vca_pkg::idx_w(NUM_PORTS)-1:0] port_i,
   output logic [NUM_PORTS*VPM-1:0][VPM-1:0]          gnt_loc_o
);

   localparam int unsigned N      = NUM_PORTS * VPM;
   localparam int unsigned PW     = vca_pkg::idx_w(N);
   localparam int unsigned PORT_W = vca_pkg::idx_w(NUM_PORTS);

   logic [N-1:0][N-1:0] req_m;
   logic [N-1:0][N-1:0] gnt_m;
   logic [N-1:0]        row_free;
   logic [N-1:0]        col_free;
   logic [PW-1:0]       diag_q;

   always_comb begin
      req_m = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         for (int j = 0; j < VPM; j++) begin
            for (int i = 0; i < N; i++) begin
               if (port_i[i] == PORT_W'(p)) begin
                  req_m[i][p*VPM+j] = req_loc_i[i][j];
               end
            end
         end
      end
   end

   // diagonals swept in order, starting from the rotating priority one
   always_comb begin
      int d;
      int s;
      gnt_m    = '0;
      row_free = '1;
      col_free = '1;
      for (int k = 0; k < N; k++) begin
         d = int'(diag_q) + k;
         if (d >= int'(N)) d = d - int'(N);
         for (int i = 0; i < N; i++) begin
            for (int o = 0; o < N; o++) begin
               s = i + o;
               if (s >= int'(N)) s = s - int'(N);
               if ((s == d) && req_m[i][o] && row_free[i] && col_free[o]) begin
                  gnt_m[i][o] = 1'b1;
                  row_free[i] = 1'b0;
                  col_free[o] = 1'b0;
               end
            end
         end
      end
   end

   always_comb begin
      gnt_loc_o = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         for (int j = 0; j < VPM; j++) begin
            for (int i = 0; i < N; i++) begin
               gnt_loc_o[i][j] = gnt_loc_o[i][j] | gnt_m[i][p*VPM+j];
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         diag_q <= '0;
      end else if (|gnt_m) begin
         diag_q <= (diag_q == PW'(N - 1)) ? '0 : diag_q + PW'(1);
      end
   end

endmodule

// File: rtl/vca_sparse.sv
module vca_sparse #(
   parameter int unsigned          NUM_PORTS   = 2,
   parameter int unsigned          NUM_MSG     = 2,
   parameter int unsigned          VCS_PER_RES = 2,
   parameter vca_pkg::alloc_kind_e ALLOC_KIND  = vca_pkg::ALLOC_SEP_IN
) (
   input  logic                                                            clk_i,
   input  logic                                                            rst_ni,
   input  logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0]                      ivc_req_i,
   input  logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0][vca_pkg::idx_w(NUM_PORTS)-1:0] ivc_port_i,
   input  logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0]                      ivc_nonmin_i,
   input  logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0]                      ovc_busy_i,
   output logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0][2*VCS_PER_RES-1:0]   ivc_gnt_o,
   output logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0]                      ovc_claim_o
);

   localparam int unsigned NUM_RES = 2;
   localparam int unsigned VPM     = NUM_RES * VCS_PER_RES;
   localparam int unsigned VPP     = NUM_MSG * VPM;
   localparam int unsigned NUM_VC  = NUM_PORTS * VPP;
   localparam int unsigned NI      = NUM_PORTS * VPM;
   localparam int unsigned PORT_W  = vca_pkg::idx_w(NUM_PORTS);

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("vca_sparse: NUM_PORTS must be at least 1");
   end
   if (NUM_MSG < 1) begin : g_bad_msg
      $error("vca_sparse: NUM_MSG must be at least 1");
   end
   if (VCS_PER_RES < 1) begin : g_bad_vcs
      $error("vca_sparse: VCS_PER_RES must be at least 1");
   end

   logic [NUM_MSG-1:0][NI-1:0][VPM-1:0]    req_loc;
   logic [NUM_MSG-1:0][NI-1:0][PORT_W-1:0] port_loc;
   logic [NUM_MSG-1:0][NI-1:0][VPM-1:0]    gnt_loc;

   // prune each input's requests to the legal, free channels of its class
   always_comb begin
      int  g;
      int  i;
      logic free_hit;
      req_loc  = '0;
      port_loc = '0;
      for (int ip = 0; ip < NUM_PORTS; ip++) begin
         for (int m = 0; m < NUM_MSG; m++) begin
            for (int l = 0; l < VPM; l++) begin
               g = ip*VPP + m*VPM + l;
               i = ip*VPM + l;
               port_loc[m][i] = ivc_port_i[g];
               for (int j = 0; j < VPM; j++) begin
                  free_hit = 1'b0;
                  for (int tp = 0; tp < NUM_PORTS; tp++) begin
                     if ((ivc_port_i[g] == PORT_W'(tp)) && !ovc_busy_i[tp*VPP + m*VPM + j]) begin
                        free_hit = 1'b1;
                     end
                  end
                  req_loc[m][i][j] = ivc_req_i[g] && free_hit &&
                                     ((j < int'(VCS_PER_RES)) || ivc_nonmin_i[g]);
               end
            end
         end
      end
   end

   for (genvar gm = 0; gm < NUM_MSG; gm++) begin : g_msg
      if (ALLOC_KIND == vca_pkg::ALLOC_WAVE) begin : g_wf
         vca_wf_core #(
            .NUM_PORTS (NUM_PORTS),
            .VPM       (VPM)
         ) u_core (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .req_loc_i (req_loc[gm]),
            .port_i    (port_loc[gm]),
            .gnt_loc_o (gnt_loc[gm])
         );
      end else begin : g_sep
         vca_sep_core #(
            .NUM_PORTS (NUM_PORTS),
            .VPM       (VPM),
            .OUT_FIRST (ALLOC_KIND == vca_pkg::ALLOC_SEP_OUT)
         ) u_core (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .req_loc_i (req_loc[gm]),
            .port_i    (port_loc[gm]),
            .gnt_loc_o (gnt_loc[gm])
         );
      end
   end

   always_comb begin
      ivc_gnt_o = '0;
      for (int ip = 0; ip < NUM_PORTS; ip++) begin
         for (int m = 0; m < NUM_MSG; m++) begin
            for (int l = 0; l < VPM; l++) begin
               ivc_gnt_o[ip*VPP + m*VPM + l] = gnt_loc[m][ip*VPM + l];
            end
         end
      end
   end

   always_comb begin
      ovc_claim_o = '0;
      for (int m = 0; m < NUM_MSG; m++) begin
         for (int i = 0; i < NI; i++) begin
            for (int j = 0; j < VPM; j++) begin
               for (int tp = 0; tp < NUM_PORTS; tp++) begin
                  if (gnt_loc[m][i][j] && (port_loc[m][i] == PORT_W'(tp))) begin
                     ovc_claim_o[tp*VPP + m*VPM + j] = 1'b1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/vca_sparse_chk.sv
module vca_sparse_chk #(
   parameter int unsigned NUM_PORTS   = 2,
   parameter int unsigned NUM_MSG     = 2,
   parameter int unsigned VCS_PER_RES = 2
) (
   input logic                                                            clk_i,
   input logic                                                            rst_ni,
   input logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0]                      ivc_req_i,
   input logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0][vca_pkg::idx_w(NUM_PORTS)-1:0] ivc_port_i,
   input logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0]                      ivc_nonmin_i,
   input logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0]                      ovc_busy_i,
   input logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0][2*VCS_PER_RES-1:0]   ivc_gnt_o,
   input logic [NUM_PORTS*NUM_MSG*2*VCS_PER_RES-1:0]                      ovc_claim_o
);

   localparam int unsigned VPM    = 2 * VCS_PER_RES;
   localparam int unsigned VPP    = NUM_MSG * VPM;
   localparam int unsigned NUM_VC = NUM_PORTS * VPP;
   localparam int unsigned PORT_W = vca_pkg::idx_w(NUM_PORTS);

   logic [NUM_VC-1:0][NUM_VC-1:0] hit;
   logic                          legal_any;

   always_comb begin
      int m;
      int o;
      hit       = '0;
      legal_any = 1'b0;
      for (int g = 0; g < NUM_VC; g++) begin
         m = (g % VPP) / VPM;
         for (int j = 0; j < VPM; j++) begin
            for (int tp = 0; tp < NUM_PORTS; tp++) begin
               o = tp*VPP + m*VPM + j;
               if (ivc_port_i[g] == PORT_W'(tp)) begin
                  hit[o][g] = ivc_gnt_o[g][j];
                  if (ivc_req_i[g] && !ovc_busy_i[o] &&
                      ((j < int'(VCS_PER_RES)) || ivc_nonmin_i[g])) begin
                     legal_any = 1'b1;
                  end
               end
            end
         end
      end
   end

   for (genvar g = 0; g < NUM_VC; g++) begin : g_in
      // R1
      gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $onehot0(ivc_gnt_o[g]));
      // R6
      gnt_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (|ivc_gnt_o[g]) |-> ivc_req_i[g]);
      // R2
      min_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !ivc_nonmin_i[g] |-> (ivc_gnt_o[g][VPM-1:VCS_PER_RES] == '0));
   end

   for (genvar o = 0; o < NUM_VC; o++) begin : g_out
      // R5
      ovc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $countones(hit[o]) <= 1);
      // R5
      claim_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ovc_claim_o[o] == (|hit[o]));
      // R4
      busy_ovc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ovc_busy_i[o] |-> !ovc_claim_o[o]);
   end

   // R7
   work_cons_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      legal_any |-> (|ovc_claim_o));

endmodule

bind vca_sparse vca_sparse_chk #(
   .NUM_PORTS   (NUM_PORTS),
   .NUM_MSG     (NUM_MSG),
   .VCS_PER_RES (VCS_PER_RES)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .ivc_req_i    (ivc_req_i),
   .ivc_port_i   (ivc_port_i),
   .ivc_nonmin_i (ivc_nonmin_i),
   .ovc_busy_i   (ovc_busy_i),
   .ivc_gnt_o    (ivc_gnt_o),
   .ovc_claim_o  (ovc_claim_o)
);

// File: tb/vca_sparse_tb_top.sv
module vca_sparse_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_PORTS  = 2;
   localparam int NUM_MSG    = 2;
   localparam int VPR        = 2;
   localparam int VPM        = 2 * VPR;
   localparam int VPP        = NUM_MSG * VPM;
   localparam int NUM_VC     = NUM_PORTS * VPP;
   localparam int PORT_W     = 1;

   typedef struct packed {
      logic [3:0] ivc;
      logic       tport;
      logic       nm;
      logic [3:0] busy;
      logic [3:0] exp;
   } vec_t;

   // single requester, target slice busy pattern (bit j = local j), expected local grant
   localparam vec_t VECS [8] = '{
      '{4'd0,  1'b1, 1'b0, 4'b1110, 4'b0001},
      '{4'd5,  1'b0, 1'b0, 4'b1101, 4'b0010},
      '{4'd10, 1'b0, 1'b1, 4'b1011, 4'b0100},
      '{4'd15, 1'b1, 1'b1, 4'b0111, 4'b1000},
      '{4'd3,  1'b1, 1'b0, 4'b0011, 4'b0000},
      '{4'd12, 1'b0, 1'b1, 4'b1111, 4'b0000},
      '{4'd9,  1'b0, 1'b1, 4'b1110, 4'b0001},
      '{4'd6,  1'b1, 1'b1, 4'b1101, 4'b0010}
   };

   logic                              clk;
   logic                              rst_n;
   logic [NUM_VC-1:0]                 req;
   logic [NUM_VC-1:0][PORT_W-1:0]     port;
   logic [NUM_VC-1:0]                 nonmin;
   logic [NUM_VC-1:0]                 busy;
   logic [NUM_VC-1:0][VPM-1:0]        gnt;
   logic [NUM_VC-1:0]                 claim;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   vca_sparse #(
      .NUM_PORTS   (NUM_PORTS),
      .NUM_MSG     (NUM_MSG),
      .VCS_PER_RES (VPR)
   ) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .ivc_req_i    (req),
      .ivc_port_i   (port),
      .ivc_nonmin_i (nonmin),
      .ovc_busy_i   (busy),
      .ivc_gnt_o    (gnt),
      .ovc_claim_o  (claim)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      req    = '0;
      port   = '0;
      nonmin = '0;
      busy   = '0;
   endtask

   // full-matrix reference with masking
   task automatic ref_check(input string tag);
      int cnt [NUM_VC];
      int bad_legal;
      int bad_conf;
      bit any_legal;
      logic [NUM_VC-1:0] exp_claim;
      int m;
      int o;
      bit lg;
      bad_legal = 0;
      bad_conf  = 0;
      any_legal = 1'b0;
      exp_claim = '0;
      for (int k = 0; k < NUM_VC; k++) cnt[k] = 0;
      for (int g = 0; g < NUM_VC; g++) begin
         m = (g % VPP) / VPM;
         if ($countones(gnt[g]) > 1) bad_legal++;
         for (int j = 0; j < VPM; j++) begin
            o  = int'(port[g])*VPP + m*VPM + j;
            lg = req[g] && ((j < VPR) || nonmin[g]) && !busy[o];
            if (lg) any_legal = 1'b1;
            if (gnt[g][j]) begin
               if (!lg) bad_legal++;
               cnt[o]++;
               exp_claim[o] = 1'b1;
            end
         end
      end
      for (int k = 0; k < NUM_VC; k++) if (cnt[k] > 1) bad_conf++;
      check({tag, " R2/R3/R4/R6 illegal grants"}, bad_legal, 0);
      check({tag, " R5 ovc conflicts"}, bad_conf, 0);
      check({tag, " R5 claim vector"}, claim, exp_claim);
      check({tag, " R7 work conserving"}, (any_legal && (claim == '0)) ? 1 : 0, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] s1;
      logic [31:0] s2;
      logic [NUM_VC-1:0] exp_claim;
      int prev_win;
      int win;
      int msg;

      clear_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R6: reset state, no requests
      #1;
      check("R6 reset grants", gnt, '0);
      check("R6 reset claims", claim, '0);

      // R1/R2/R3/R4 table
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         clear_inputs();
         req[VECS[v].ivc]    = 1'b1;
         port[VECS[v].ivc]   = VECS[v].tport;
         nonmin[VECS[v].ivc] = VECS[v].nm;
         msg = int'(VECS[v].ivc[2]);
         for (int j = 0; j < VPM; j++) begin
            busy[int'(VECS[v].tport)*VPP + msg*VPM + j] = VECS[v].busy[j];
         end
         exp_claim = '0;
         for (int j = 0; j < VPM; j++) begin
            if (VECS[v].exp[j]) exp_claim[int'(VECS[v].tport)*VPP + msg*VPM + j] = 1'b1;
         end
         #1;
         check($sformatf("R1/R2/R3/R4 vector %0d grant", v), gnt[VECS[v].ivc], VECS[v].exp);
         check($sformatf("R5 vector %0d claim", v), claim, exp_claim);
         ref_check($sformatf("vector %0d", v));
      end

      // R1: two inputs, two different free channels, both granted
      @(negedge clk);
      clear_inputs();
      req[1]  = 1'b1; port[1]  = 1'b0;
      req[13] = 1'b1; port[13] = 1'b0;
      busy[3:0] = 4'b1110;
      busy[7:4] = 4'b1101;
      #1;
      check("R1 dual grant ivc1", gnt[1], 4'b0001);
      check("R1 dual grant ivc13", gnt[13], 4'b0010);
      check("R5 dual claim", claim, 16'h0021);
      ref_check("dual");

      // R4: busy release usable in the same cycle
      @(negedge clk);
      clear_inputs();
      req[4] = 1'b1; port[4] = 1'b1; nonmin[4] = 1'b1;
      busy[15:12] = 4'b1111;
      #1;
      check("R4 all busy no grant", gnt[4], 4'b0000);
      @(negedge clk);
      busy[14] = 1'b0;
      #1;
      check("R4 released channel granted", gnt[4], 4'b0100);
      check("R5 released channel claimed", claim, 16'h4000);

      // R8: contention for a single free channel, other minimal channel busy
      @(negedge clk);
      clear_inputs();
      req[0] = 1'b1; port[0] = 1'b1;
      req[8] = 1'b1; port[8] = 1'b1;
      busy[11:8] = 4'b1110;
      prev_win = -1;
      for (int c = 0; c < 6; c++) begin
         if (c > 0) @(negedge clk);
         #1;
         check($sformatf("R8 single winner cycle %0d", c),
               $countones({gnt[0], gnt[8]}), 1);
         win = (gnt[0] != '0) ? 0 : 8;
         if (prev_win >= 0) begin
            check($sformatf("R8 alternation cycle %0d", c), win, (prev_win == 0) ? 8 : 0);
         end
         ref_check($sformatf("R8 cycle %0d", c));
         prev_win = win;
      end

      // R6: request dropped, grant disappears
      @(negedge clk);
      clear_inputs();
      busy = 16'h0000;
      nonmin = 16'hFFFF;
      #1;
      check("R6 no request no grant", gnt, '0);

      // randomised load, busy flags changing every cycle
      s1 = 32'h1ACE_B00C;
      s2 = 32'h7F3A_5D21;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         s1 = {s1[30:0], s1[31] ^ s1[21] ^ s1[1] ^ s1[0]};
         s1 = {s1[30:0], s1[31] ^ s1[21] ^ s1[1] ^ s1[0]};
         s2 = {s2[30:0], s2[31] ^ s2[21] ^ s2[1] ^ s2[0]};
         req    = s1[15:0];
         nonmin = s2[15:0];
         busy   = s1[31:16] & s2[31:16];
         for (int g = 0; g < NUM_VC; g++) port[g] = s2[(g + c) % 32];
         #1;
         ref_check($sformatf("random cycle %0d", c));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule